// File: doc/BRIEF.md
# Data Watchpoint Comparator Bank

This block is a bank of hardware watchpoint units that observe the data accesses of a processing element. Every unit holds an address value and a small control word. An access presented at the inputs is compared against all units in parallel. A unit matches only when all of these are true:

- the unit is enabled;
- the access is a data load or store, not an instruction fetch;
- the access direction is one the unit accepts;
- the address agrees with the stored value once a programmable number of low bits is ignored;
- if the unit is linked, the selected context-match input is high in the same cycle.

The lowest-numbered matching unit is registered and reported as a hit with its index one clock later.

The debug logic programs the units through a simple write port that selects a unit and either its value or its control word. The number of units is a build parameter from 2 to 16, and the bank reports it on a constant identification output so that software can discover it. Sub-word byte selection is not part of this block.

Top module: `wpt_bank`

## Requirements
- R1: After reset `hit_o` is 0 and every unit is disabled, so no access hits until a unit is configured. `num_units_o` always equals the parameter NUM_UNITS.
- R2: A unit whose control bit 0 (enable) is 0 never matches.
- R3: An access with `acc_fetch` high never produces a hit, whatever its address.
- R4: Control bit 1 lets a unit hit on reads (`acc_write`=0), and control bit 2 lets it hit on writes (`acc_write`=1). With both bits set it hits on either direction; with neither set it never hits.
- R5: Control bits 12:8 hold a mask count. A count of 0 compares the full address. A count N from 3 to 31 ignores address bits N-1:0 on both the stored value and the access address, so one unit covers an aligned 2^N-byte range even when the stored value has stray low bits.
- R6: A mask count of 1 or 2 is reserved and makes the unit never match.
- R7: When control bit 3 (link) is set, the unit hits only if `ctx_match[sel]` is high in the same cycle, where `sel` is control bits 7:4.
- R8: When several units match, the lowest-numbered one is reported. `hit_o` and `hit_idx_o` change on the clock edge that follows the access cycle, and `hit_idx_o` is 0 when there is no hit.
- R9: No hit is reported for a cycle in which `acc_valid` is 0.
- R10: A write with `cfg_we`=1 updates unit `cfg_idx`: the value register when `cfg_sel`=0, or the control register (bits 12:0 of `cfg_wdata`) when `cfg_sel`=1. The new setting governs accesses from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Unit selected by the write |
| cfg_sel | input | 1 | 0 = value register, 1 = control register |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | A data-side access is presented |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | Access is an instruction fetch |
| ctx_match | input | 16 | External linked-context match vector |
| hit_o | output | 1 | Registered watchpoint hit |
| hit_idx_o | output | IDX_W | Index of the reported unit |
| num_units_o | output | CNT_W | Number of units implemented |

## Verification
The bench builds the bank with five units and 32-bit addresses. The unit count is not a power of two, so the index field has spare codes beyond the last unit, and the identification output must read a value other than a round binary size. Five units give enough overlapping comparators to exercise priority among three or more simultaneous matches. The 32-bit address reaches the largest mask count of 31, where only the top address bit is compared.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int CTX_N   = 16;
  localparam int LINK_W  = 4;
  localparam int MCNT_W  = 5;
  localparam int CTL_W   = 13;

  // control word layout, MSB first
  typedef struct packed {
    logic [MCNT_W-1:0] mask_cnt;   // 12:8
    logic [LINK_W-1:0] link_sel;   // 7:4
    logic              link_en;    // 3
    logic              on_store;   // 2
    logic              on_load;    // 1
    logic              en;         // 0
  } wpt_ctl_t;

  function automatic logic cnt_reserved(input logic [MCNT_W-1:0] cnt);
    return (cnt == MCNT_W'(1)) || (cnt == MCNT_W'(2));
  endfunction

  function automatic logic dir_ok(input wpt_ctl_t c, input logic is_write);
    return is_write ? c.on_store : c.on_load;
  endfunction

  function automatic logic link_ok(input wpt_ctl_t c, input logic [CTX_N-1:0] ctx);
    return !c.link_en || ctx[c.link_sel];
  endfunction
endpackage

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_val,
  input  logic                 wr_ctl,
  input  logic [ADDR_W-1:0]    val_in,
  input  logic [CTL_W-1:0]     ctl_in,
  input  logic                 acc_valid,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_write,
  input  logic                 acc_fetch,
  input  logic [CTX_N-1:0]     ctx_match,
  output logic                 hit
);
  logic [ADDR_W-1:0] value_q;
  wpt_ctl_t          ctl_q;
  logic [ADDR_W-1:0] keep_mask;
  logic              addr_eq;
  logic              qual_ok;

  // bits kept in the compare: all for count 0, upper bits otherwise
  function automatic logic [ADDR_W-1:0] keep_bits(input logic [MCNT_W-1:0] cnt);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) m[b] = (b >= int'(cnt));
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      ctl_q   <= '0;
    end else begin
      if (wr_val) value_q <= val_in;
      if (wr_ctl) ctl_q   <= wpt_ctl_t'(ctl_in);
    end
  end

  always_comb begin
    keep_mask = keep_bits(ctl_q.mask_cnt);
    addr_eq   = ((value_q & keep_mask) == (acc_addr & keep_mask));
    qual_ok   = acc_valid && !acc_fetch && ctl_q.en &&
                !cnt_reserved(ctl_q.mask_cnt) &&
                dir_ok(ctl_q, acc_write) && link_ok(ctl_q, ctx_match);
    hit       = qual_ok && addr_eq;
  end
endmodule

// File: rtl/wpt_prio.sv
module wpt_prio #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wpt_bank.sv
module wpt_bank
  import wpt_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int CNT_W    = $clog2(NUM_UNITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic [CTX_N-1:0]  ctx_match,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [CNT_W-1:0]  num_units_o
);
  logic [NUM_UNITS-1:0] raw_hit;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;

  assign num_units_o = CNT_W'(NUM_UNITS);

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    logic sel_me;
    assign sel_me = cfg_we && (cfg_idx == IDX_W'(i));
    wpt_unit #(.ADDR_W(ADDR_W)) unit_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_val    (sel_me && !cfg_sel),
      .wr_ctl    (sel_me && cfg_sel),
      .val_in    (cfg_wdata),
      .ctl_in    (cfg_wdata[CTL_W-1:0]),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_write (acc_write),
      .acc_fetch (acc_fetch),
      .ctx_match (ctx_match),
      .hit       (raw_hit[i])
    );
  end

  wpt_prio #(.N(NUM_UNITS), .IDX_W(IDX_W)) prio_i (
    .req (raw_hit),
    .any (any_hit),
    .idx (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      hit_o     <= any_hit;
      hit_idx_o <= any_hit ? win_idx : '0;
    end
  end
endmodule

// File: rtl/wpt_bank_chk.sv
module wpt_bank_chk #(
  parameter int NUM_UNITS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_fetch,
  input logic [NUM_UNITS-1:0] raw_hit,
  input logic                 hit_o,
  input logic [IDX_W-1:0]     hit_idx_o
);
  logic [NUM_UNITS-1:0] prev_raw;
  logic                 below_clear;
  logic                 idx_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_raw <= '0;
    else        prev_raw <= raw_hit;
  end

  always_comb begin
    below_clear = 1'b1;
    idx_set     = 1'b0;
    for (int j = 0; j < NUM_UNITS; j++) begin
      if (j < int'(hit_idx_o) && prev_raw[j]) below_clear = 1'b0;
      if (j == int'(hit_idx_o) && prev_raw[j]) idx_set = 1'b1;
    end
  end

  // R3: fetches never hit
  assert_fetch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fetch) |-> (raw_hit == '0));
  // R9: no access, no match
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (raw_hit == '0));
  // R8: a match is reported one edge later
  assert_hit_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit != '0) |=> hit_o);
  assert_nohit_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit == '0) |=> !hit_o);
  // R8: the reported index is the lowest unit that matched
  assert_lowest_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (idx_set && below_clear));
  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (int'(hit_idx_o) < NUM_UNITS));
endmodule

bind wpt_bank wpt_bank_chk #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_fetch (acc_fetch),
  .raw_hit   (raw_hit),
  .hit_o     (hit_o),
  .hit_idx_o (hit_idx_o)
);

// File: tb/wpt_bank_tb.sv
module wpt_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 5;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_write = 1'b0;
  logic          acc_fetch = 1'b0;
  logic [15:0]   ctx_match = '0;
  logic          hit_o;
  logic [IW-1:0] hit_idx_o;
  logic [CW-1:0] num_units_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_val [NU];
  logic [12:0]   m_ctl [NU];

  always #(CLK_PERIOD/2) clk = ~clk;

  wpt_bank #(.NUM_UNITS(NU), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .ctx_match(ctx_match), .hit_o(hit_o), .hit_idx_o(hit_idx_o),
    .num_units_o(num_units_o)
  );

  function automatic logic model_unit(int i, logic v, logic [AW-1:0] a,
                                      logic w, logic f, logic [15:0] c);
    logic [12:0] k = m_ctl[i];
    int cnt = int'(k[12:8]);
    logic [AW-1:0] diff = a ^ m_val[i];
    if (!v || f || !k[0]) return 1'b0;
    if (cnt == 1 || cnt == 2) return 1'b0;
    if (w ? !k[2] : !k[1]) return 1'b0;
    if (k[3] && !c[k[7:4]]) return 1'b0;
    diff = (diff >> cnt);
    return diff == '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int idx, logic sel, logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_sel = sel; cfg_wdata = d;
    if (idx < NU) begin
      if (sel) m_ctl[idx] = d[12:0]; else m_val[idx] = d;
    end
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // access for one cycle; check the registered result one edge later
  task automatic acc(string tag, logic v, logic [AW-1:0] a, logic w,
                     logic f, logic [15:0] c);
    logic eh = 1'b0;
    int ei = 0;
    acc_valid = v; acc_addr = a; acc_write = w; acc_fetch = f; ctx_match = c;
    for (int i = NU - 1; i >= 0; i--)
      if (model_unit(i, v, a, w, f, c)) begin eh = 1'b1; ei = i; end
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    check({tag, " hit"}, 32'(hit_o), 32'(eh));
    check({tag, " idx"}, 32'(hit_idx_o), 32'(ei));
  endtask

  function automatic logic [12:0] mk(int mcnt, int lsel, bit lnk, bit st, bit ld, bit en);
    return {5'(mcnt), 4'(lsel), lnk, st, ld, en};
  endfunction

  initial begin
    for (int i = 0; i < NU; i++) begin m_val[i] = '0; m_ctl[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset hit", 32'(hit_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 num_units", 32'(num_units_o), NU);
    acc("R1 unconfigured", 1, 32'h0, 0, 0, 16'h0);

    cfg(0, 0, 32'h4000_1000);
    acc("R2 disabled", 1, 32'h4000_1000, 0, 0, 16'h0);
    cfg(0, 1, 32'(mk(0, 0, 0, 1, 1, 1)));
    acc("R10 exact hit", 1, 32'h4000_1000, 0, 0, 16'h0);
    acc("R5 exact miss", 1, 32'h4000_1001, 0, 0, 16'h0);
    acc("R3 fetch", 1, 32'h4000_1000, 0, 1, 16'h0);
    acc("R9 idle", 0, 32'h4000_1000, 0, 0, 16'h0);

    cfg(1, 0, 32'h5000_2000);
    cfg(1, 1, 32'(mk(0, 0, 0, 0, 1, 1)));
    acc("R4 load only read", 1, 32'h5000_2000, 0, 0, 16'h0);
    acc("R4 load only write", 1, 32'h5000_2000, 1, 0, 16'h0);
    cfg(1, 1, 32'(mk(0, 0, 0, 1, 0, 1)));
    acc("R4 store only read", 1, 32'h5000_2000, 0, 0, 16'h0);
    acc("R4 store only write", 1, 32'h5000_2000, 1, 0, 16'h0);
    cfg(1, 1, 32'(mk(0, 0, 0, 0, 0, 1)));
    acc("R4 no direction", 1, 32'h5000_2000, 1, 0, 16'h0);

    cfg(2, 0, 32'h6000_30a7);
    cfg(2, 1, 32'(mk(12, 0, 0, 1, 1, 1)));
    acc("R5 range low", 1, 32'h6000_3000, 0, 0, 16'h0);
    acc("R5 range high", 1, 32'h6000_3fff, 1, 0, 16'h0);
    acc("R5 range out", 1, 32'h6000_4000, 0, 0, 16'h0);
    cfg(2, 1, 32'(mk(31, 0, 0, 1, 1, 1)));
    acc("R5 count 31", 1, 32'h7fff_ffff, 0, 0, 16'h0);
    cfg(2, 1, 32'(mk(1, 0, 0, 1, 1, 1)));
    acc("R6 count 1", 1, 32'h6000_30a7, 0, 0, 16'h0);
    cfg(2, 1, 32'(mk(2, 0, 0, 1, 1, 1)));
    acc("R6 count 2", 1, 32'h6000_30a6, 0, 0, 16'h0);

    cfg(3, 0, 32'h7000_0040);
    cfg(3, 1, 32'(mk(3, 9, 1, 1, 1, 1)));
    acc("R7 link low", 1, 32'h7000_0044, 0, 0, 16'hfdff);
    acc("R7 link high", 1, 32'h7000_0044, 0, 0, 16'h0200);

    cfg(4, 0, 32'h6000_3000);
    cfg(4, 1, 32'(mk(4, 0, 0, 1, 1, 1)));
    cfg(2, 1, 32'(mk(12, 0, 0, 1, 1, 1)));
    acc("R8 two match", 1, 32'h6000_3008, 0, 0, 16'h0);
    cfg(2, 1, 32'(mk(12, 0, 0, 0, 0, 0)));
    acc("R8 only upper", 1, 32'h6000_3008, 0, 0, 16'h0);

    void'($urandom(32'd20251));
    for (int k = 0; k < 4000; k++) begin
      if (k % 50 == 0) begin
        for (int u = 0; u < NU; u++) begin
          int mc;
          case ($urandom_range(0, 8))
            0, 1: mc = 0; 2: mc = 3; 3: mc = 4; 4: mc = 8;
            5: mc = 12; 6: mc = 1; 7: mc = 2; default: mc = 31;
          endcase
          cfg(u, 0, 32'h8000_0000 | 32'($urandom_range(0, 3) << 8) | 32'($urandom_range(0, 15)));
          cfg(u, 1, 32'(mk(mc, $urandom_range(0, 15), ($urandom_range(0, 3) == 0),
                           $urandom_range(0, 1), $urandom_range(0, 1),
                           ($urandom_range(0, 5) != 0))));
        end
      end
      acc("R8 random", ($urandom_range(0, 7) != 0),
          32'h8000_0000 | 32'($urandom_range(0, 3) << 8) | 32'($urandom_range(0, 31)),
          $urandom_range(0, 1), ($urandom_range(0, 7) == 0), 16'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule